// File: doc/BRIEF.md
# Health-Monitor Interrupt and Reset Register Block

This block is the byte-wide register front end of a system health monitor. It has a small I/O window of 16 byte locations. It gathers live status from a watchdog, a temperature comparator, the supply comparators, a fan controller and two isolated inputs. It raises a single interrupt request and a single reset request, and it drives two discrete outputs and a few control lines.

Each interrupt source has its own enable bit. A source that fires while it is enabled is captured in a sticky pending flag, so a one-cycle event is not lost. A global interrupt enable sits above all the pending flags. Reads have side effects, and software uses them as commands:
- Reading the status location turns the global enable on.
- Reading the disable location turns it off.
- Reading the image location only observes.

Bit 7 of any of these three reads reports a pending request only if the global enable was on when the read happened. A read or a write acts once per strobe, on the strobe's rising edge, however long the strobe is held.

Top module: `hmon_regs`

## Requirements
- R1: After reset the following are all 0: irq, rst_req, out1, out2, wdt_en, tmr_slow, fan_tgl, the global enable and every source enable, so a control read returns 0x00.
- R2: Reads of locations 0x0, 0x1 and 0x2 return the status byte, whose bits are as follows:
  - bit0 = NOT wdt_warn
  - bit1 = temp_over
  - bit2 = iso_in2
  - bit3 = iso_in1
  - bit4 = fan_ok
  - bit5 = NOT ov5
  - bit6 = NOT uv5
  - bit7 = global enable AND any pending, taken before the read's own effect
- R3: A read of the image location 0x1 changes neither the global enable nor any pending flag.
- R4: A read of the status location 0x0 sets the global enable. It clears all pending flags only if the global enable was already on at that read, so reading after interrupts were disabled shows bit7 = 0 and the next status read shows bit7 = 1.
- R5: A read of the disable location 0x2 clears the global enable. It reports bit7 = 1 if a request was pending while enabled, and a second read reports bit7 = 0. Pending flags are kept.
- R6: Source i sets pending flag i whenever it is high while bit i of the source-enable register at 0x3 is set. The sources in bit order are wdt_expired, temp_over, ov5, uv5, flt12p, flt12n and fan_limit. A source that is high in the same cycle as a clearing status read keeps its flag.
- R7: irq is high exactly when the global enable is on and at least one pending flag is set. It follows one clock edge after the causing event.
- R8: Bit 7 of a write to 0x3 or to the control location 0x4 loads the global enable, so writing 1 turns interrupts on and writing 0 turns them off. Both locations read back the global enable in bit 7.
- R9: rst_req is the registered OR of three terms: wdt_expired; pb_n low while control bit5 is set; and iso_in2 high while control bit3 is set.
- R10: A write of any value to 0x5 turns out1 on and a read of 0x5 turns it off. Location 0x6 does the same for out2. Control bits 1 and 2 load out1 and out2 and read back their state.
- R11: A read strobe held high for several cycles has its side effects and its data capture only once, at its first cycle.
- R12: The following control bits drive the matching outputs and read back in place:
  - bit0 drives wdt_en
  - bit3 is the isolated-input reset enable
  - bit4 drives tmr_slow
  - bit5 is the pushbutton reset enable
  - bit6 drives fan_tgl

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register location |
| rd | input | 1 | Read strobe, acts on rising edge |
| wr | input | 1 | Write strobe, acts on rising edge |
| wdata | input | 8 | Write data |
| wdt_expired | input | 1 | Watchdog timeout |
| wdt_warn | input | 1 | Watchdog refresh reminder |
| temp_over | input | 1 | Over-temperature comparator |
| ov5 | input | 1 | 5 V overvoltage |
| uv5 | input | 1 | 5 V undervoltage |
| flt12p | input | 1 | +12 V fault |
| flt12n | input | 1 | -12 V fault |
| fan_limit | input | 1 | Fan drive at zero or full power |
| fan_ok | input | 1 | Fan good |
| iso_in1 | input | 1 | Isolated input 1 |
| iso_in2 | input | 1 | Isolated input 2 |
| pb_n | input | 1 | Pushbutton reset, active low |
| rdata | output | 8 | Read data, captured at the read strobe |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | Reset request |
| out1 | output | 1 | Discrete output 1 |
| out2 | output | 1 | Discrete output 2 |
| wdt_en | output | 1 | Watchdog enable |
| tmr_slow | output | 1 | Slow timer clock select |
| fan_tgl | output | 1 | Fan start/stop toggle |

## Verification
Two functions can meet in one clock edge: a status read clearing the pending flags, and a new enabled source event setting one. The bench provokes this by raising ov5 in the very cycle of a status read made while another flag is pending. It then checks three things: the captured byte shows ov5 live, irq stays high afterwards, and only a further status read drops it. A held read strobe is also judged by its single effect. A request pending while interrupts were off must read bit7 = 0 once and leave irq high; it must not be cleared by the later cycles of the same strobe.

// File: rtl/hmon_pkg.sv
package hmon_pkg;
  localparam int AW   = 4;
  localparam int DW   = 8;
  localparam int NSRC = 7;
  localparam int NREG = 7;

  localparam logic [AW-1:0] A_STAT = 4'h0;
  localparam logic [AW-1:0] A_IMG  = 4'h1;
  localparam logic [AW-1:0] A_DIS  = 4'h2;
  localparam logic [AW-1:0] A_IEN  = 4'h3;
  localparam logic [AW-1:0] A_CTRL = 4'h4;
  localparam logic [AW-1:0] A_OUT1 = 4'h5;
  localparam logic [AW-1:0] A_OUT2 = 4'h6;

  typedef struct packed {
    logic fan_tgl;
    logic pb_en;
    logic slow;
    logic iso2_en;
    logic wdt_en;
  } ctrl_t;
endpackage

// File: rtl/hmon_bus_if.sv
module hmon_bus_if #(
  parameter int AW   = 4,
  parameter int NREG = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  output logic            rd_p,
  output logic            wr_p,
  output logic [NREG-1:0] sel
);
  logic rd_q, wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd;
      wr_q <= wr;
    end
  end

  assign rd_p = rd & ~rd_q;
  assign wr_p = wr & ~wr_q;

  for (genvar k = 0; k < NREG; k++) begin : g_dec
    assign sel[k] = (addr == AW'(k));
  end

  // R11: a held strobe yields a single action
  a_r11_single_read_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_p |=> !rd_p);
  a_r11_single_write_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_p |=> !wr_p);
endmodule

// File: rtl/hmon_irq_ctrl.sv
module hmon_irq_ctrl #(
  parameter int DW   = 8,
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_p,
  input  logic            wr_p,
  input  logic            sel_stat,
  input  logic            sel_dis,
  input  logic            sel_ien,
  input  logic            sel_ctrl,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] src,
  output logic            ie,
  output logic [NSRC-1:0] ien,
  output logic            any_pend,
  output logic            irq
);
  logic [NSRC-1:0] pend, pend_nxt;
  logic            ie_nxt, clr;

  // flags are only consumed by a status read that saw them reported
  assign clr = rd_p & sel_stat & ie;

  always_comb begin
    ie_nxt = ie;
    if (wr_p && (sel_ien || sel_ctrl)) ie_nxt = wdata[DW-1];
    if (rd_p && sel_stat)              ie_nxt = 1'b1;
    if (rd_p && sel_dis)               ie_nxt = 1'b0;
  end

  assign pend_nxt = (clr ? '0 : pend) | (src & ien);

  always_ff @(posedge clk) begin
    if (rst) begin
      ie   <= 1'b0;
      ien  <= '0;
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      ie   <= ie_nxt;
      pend <= pend_nxt;
      irq  <= ie_nxt & (|pend_nxt);
      if (wr_p && sel_ien) ien <= wdata[NSRC-1:0];
    end
  end

  assign any_pend = |pend;

  a_r4_status_read_enables: assert property (@(posedge clk) disable iff (rst)
    (rd_p && sel_stat) |=> ie);
  a_r5_disable_read_masks: assert property (@(posedge clk) disable iff (rst)
    (rd_p && sel_dis) |=> (!ie && !irq));
  a_r6_pending_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((pend & $past(pend)) == $past(pend)));
  a_r6_enabled_source_latches: assert property (@(posedge clk) disable iff (rst)
    (|(src & ien)) |=> any_pend);
endmodule

// File: rtl/hmon_reset_out.sv
module hmon_reset_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_p,
  input  logic       wr_p,
  input  logic       sel_ctrl,
  input  logic       sel_out1,
  input  logic       sel_out2,
  input  logic [6:0] wbits,
  input  logic       wdt_expired,
  input  logic       pb_n,
  input  logic       iso_in2,
  output hmon_pkg::ctrl_t ctrl,
  output logic       out1,
  output logic       out2,
  output logic       rst_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      out1 <= 1'b0;
      out2 <= 1'b0;
    end else begin
      if (wr_p && sel_ctrl) begin
        ctrl.wdt_en  <= wbits[0];
        ctrl.iso2_en <= wbits[3];
        ctrl.slow    <= wbits[4];
        ctrl.pb_en   <= wbits[5];
        ctrl.fan_tgl <= wbits[6];
      end
      if (wr_p && sel_ctrl)      out1 <= wbits[1];
      else if (wr_p && sel_out1) out1 <= 1'b1;
      else if (rd_p && sel_out1) out1 <= 1'b0;
      if (wr_p && sel_ctrl)      out2 <= wbits[2];
      else if (wr_p && sel_out2) out2 <= 1'b1;
      else if (rd_p && sel_out2) out2 <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rst_req <= 1'b0;
    else     rst_req <= wdt_expired | (ctrl.pb_en & ~pb_n) | (ctrl.iso2_en & iso_in2);
  end

  a_r10_out1_write_sets: assert property (@(posedge clk) disable iff (rst)
    (wr_p && sel_out1) |=> out1);
  a_r10_out2_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_p && sel_out2 && !wr_p) |=> !out2);
  a_r9_pushbutton_resets: assert property (@(posedge clk) disable iff (rst)
    (ctrl.pb_en && !pb_n) |=> rst_req);
  a_r9_watchdog_resets: assert property (@(posedge clk) disable iff (rst)
    wdt_expired |=> rst_req);
endmodule

// File: rtl/hmon_regs.sv
module hmon_regs #(
  parameter int AW   = hmon_pkg::AW,
  parameter int DW   = hmon_pkg::DW,
  parameter int NSRC = hmon_pkg::NSRC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          wdt_expired,
  input  logic          wdt_warn,
  input  logic          temp_over,
  input  logic          ov5,
  input  logic          uv5,
  input  logic          flt12p,
  input  logic          flt12n,
  input  logic          fan_limit,
  input  logic          fan_ok,
  input  logic          iso_in1,
  input  logic          iso_in2,
  input  logic          pb_n,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          rst_req,
  output logic          out1,
  output logic          out2,
  output logic          wdt_en,
  output logic          tmr_slow,
  output logic          fan_tgl
);
  import hmon_pkg::*;

  logic            rd_p, wr_p, ie, any_pend;
  logic [NREG-1:0] sel;
  logic [NSRC-1:0] ien, src;
  ctrl_t           ctrl;
  logic [DW-1:0]   stat_b, rd_mux;

  hmon_bus_if #(.AW(AW), .NREG(NREG)) u_bus (
    .clk(clk), .rst(rst), .rd(rd), .wr(wr), .addr(addr),
    .rd_p(rd_p), .wr_p(wr_p), .sel(sel)
  );

  assign src = {fan_limit, flt12n, flt12p, uv5, ov5, temp_over, wdt_expired};

  hmon_irq_ctrl #(.DW(DW), .NSRC(NSRC)) u_irq (
    .clk(clk), .rst(rst), .rd_p(rd_p), .wr_p(wr_p),
    .sel_stat(sel[A_STAT]), .sel_dis(sel[A_DIS]),
    .sel_ien(sel[A_IEN]), .sel_ctrl(sel[A_CTRL]),
    .wdata(wdata), .src(src),
    .ie(ie), .ien(ien), .any_pend(any_pend), .irq(irq)
  );

  hmon_reset_out u_rso (
    .clk(clk), .rst(rst), .rd_p(rd_p), .wr_p(wr_p),
    .sel_ctrl(sel[A_CTRL]), .sel_out1(sel[A_OUT1]), .sel_out2(sel[A_OUT2]),
    .wbits(wdata[6:0]), .wdt_expired(wdt_expired), .pb_n(pb_n), .iso_in2(iso_in2),
    .ctrl(ctrl), .out1(out1), .out2(out2), .rst_req(rst_req)
  );

  assign wdt_en   = ctrl.wdt_en;
  assign tmr_slow = ctrl.slow;
  assign fan_tgl  = ctrl.fan_tgl;

  assign stat_b = {ie & any_pend, ~uv5, ~ov5, fan_ok, iso_in1, iso_in2, temp_over, ~wdt_warn};

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_STAT, A_IMG, A_DIS: rd_mux = stat_b;
      A_IEN:  rd_mux = {ie, ien};
      A_CTRL: rd_mux = {ie, ctrl.fan_tgl, ctrl.pb_en, ctrl.slow, ctrl.iso2_en,
                        out2, out1, ctrl.wdt_en};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata <= '0;
    else if (rd_p) rdata <= rd_mux;
  end

  // R11: read data only changes on a fresh read strobe
  a_r11_rdata_held: assert property (@(posedge clk) disable iff (rst)
    !rd_p |=> $stable(rdata));
endmodule

// File: tb/hmon_regs_tb_top.sv
`timescale 1ns/1ps
module hmon_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] addr;
  logic       rd, wr;
  logic [7:0] wdata;
  logic       wdt_expired, wdt_warn, temp_over, ov5, uv5, flt12p, flt12n;
  logic       fan_limit, fan_ok, iso_in1, iso_in2, pb_n;
  logic [7:0] rdata;
  logic       irq, rst_req, out1, out2, wdt_en, tmr_slow, fan_tgl;

  int checks = 0;
  int errors = 0;
  logic [7:0] v;

  localparam logic [3:0] STAT = 4'h0, IMG = 4'h1, DIS = 4'h2, IEN = 4'h3,
                         CTRL = 4'h4, OUT1 = 4'h5, OUT2 = 4'h6;
  localparam logic [7:0] IDLE = 8'h71;

  always #2 clk = ~clk;

  hmon_regs dut_i (
    .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .wdt_expired(wdt_expired), .wdt_warn(wdt_warn), .temp_over(temp_over),
    .ov5(ov5), .uv5(uv5), .flt12p(flt12p), .flt12n(flt12n),
    .fan_limit(fan_limit), .fan_ok(fan_ok), .iso_in1(iso_in1), .iso_in2(iso_in2),
    .pb_n(pb_n), .rdata(rdata), .irq(irq), .rst_req(rst_req), .out1(out1),
    .out2(out2), .wdt_en(wdt_en), .tmr_slow(tmr_slow), .fan_tgl(fan_tgl)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic pulse_temp();
    @(negedge clk); temp_over = 1'b1;
    @(negedge clk); temp_over = 1'b0;
  endtask

  task automatic pulse_ov5();
    @(negedge clk); ov5 = 1'b1;
    @(negedge clk); ov5 = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rst_req", {7'd0, rst_req}, 8'h00);
    chk("R1 outs", {3'd0, out1, out2, wdt_en, tmr_slow, fan_tgl}, 8'h00);
    rd_reg(CTRL, v); chk("R1 ctrl read", v, 8'h00);
    rd_reg(IEN, v);  chk("R1 ien read", v, 8'h00);
    rd_reg(IMG, v);  chk("R2 idle status", v, IDLE);
  endtask

  task automatic t_layout();
    @(negedge clk);
    iso_in1 = 1; iso_in2 = 1; temp_over = 1; wdt_warn = 1; fan_ok = 0; ov5 = 1;
    rd_reg(IMG, v); chk("R2 status layout", v, 8'h4E);
    @(negedge clk);
    iso_in1 = 0; iso_in2 = 0; temp_over = 0; wdt_warn = 0; fan_ok = 1; ov5 = 0;
    rd_reg(IMG, v); chk("R2 status restored", v, IDLE);
  endtask

  task automatic t_enable_seq();
    wr_reg(IEN, 8'h02);
    pulse_temp();
    chk("R7 irq masked while disabled", {7'd0, irq}, 8'h00);
    rd_reg(STAT, v); chk("R4 first status read bit7 low", v, IDLE);
    chk("R4 irq after enabling read", {7'd0, irq}, 8'h01);
    rd_reg(STAT, v); chk("R4 second status read bit7 high", v, 8'hF1);
    chk("R6 status read clears pending", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_disable();
    pulse_temp();
    chk("R7 irq on pending", {7'd0, irq}, 8'h01);
    rd_reg(DIS, v); chk("R5 disable read bit7", v, 8'hF1);
    chk("R5 irq dropped", {7'd0, irq}, 8'h00);
    rd_reg(DIS, v); chk("R5 second disable read", v, IDLE);
    rd_reg(STAT, v); chk("R5 pending kept, reads low once", v, IDLE);
    chk("R5 irq back after enable", {7'd0, irq}, 8'h01);
    rd_reg(STAT, v); chk("R4 reports and clears", v, 8'hF1);
  endtask

  task automatic t_image();
    pulse_temp();
    rd_reg(IMG, v); chk("R3 image read 1", v, 8'hF1);
    rd_reg(IMG, v); chk("R3 image read 2", v, 8'hF1);
    chk("R3 irq unchanged", {7'd0, irq}, 8'h01);
    rd_reg(STAT, v);
    chk("R3 cleared only by status", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_gating();
    pulse_ov5();
    chk("R6 disabled source ignored", {7'd0, irq}, 8'h00);
    rd_reg(IMG, v); chk("R6 no pending from masked source", v, IDLE);
    wr_reg(IEN, 8'h86);
    rd_reg(IEN, v); chk("R8 ien readback", v, 8'h86);
    pulse_ov5();
    chk("R6 enabled source latched", {7'd0, irq}, 8'h01);
    rd_reg(STAT, v); chk("R6 report", v, 8'hF1);
  endtask

  task automatic t_collision();
    pulse_temp();
    @(negedge clk); addr = STAT; rd = 1'b1; ov5 = 1'b1;
    @(negedge clk); rd = 1'b0; ov5 = 1'b0;
    chk("R2 live ov5 in captured byte", rdata, 8'hD1);
    chk("R6 event during clearing read survives", {7'd0, irq}, 8'h01);
    rd_reg(STAT, v); chk("R6 survivor reported", v, 8'hF1);
    chk("R6 survivor cleared", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_held();
    rd_reg(DIS, v);
    pulse_ov5();
    chk("R7 pending while disabled", {7'd0, irq}, 8'h00);
    @(negedge clk); addr = STAT; rd = 1'b1;
    repeat (3) @(negedge clk);
    rd = 1'b0;
    chk("R11 held read captured once", rdata, IDLE);
    chk("R11 held read did not clear", {7'd0, irq}, 8'h01);
    rd_reg(STAT, v); chk("R11 next read reports", v, 8'hF1);
  endtask

  task automatic t_global();
    rd_reg(DIS, v);
    wr_reg(CTRL, 8'h80);
    rd_reg(CTRL, v); chk("R8 ctrl bit7 enables", v, 8'h80);
    wr_reg(CTRL, 8'h00);
    rd_reg(CTRL, v); chk("R8 ctrl bit7 disables", v, 8'h00);
    wr_reg(IEN, 8'h84);
    rd_reg(CTRL, v); chk("R8 ien bit7 enables", v, 8'h80);
    wr_reg(IEN, 8'h04);
    rd_reg(IEN, v); chk("R8 ien bit7 disables", v, 8'h04);
  endtask

  task automatic t_outputs();
    wr_reg(OUT1, 8'h00);
    chk("R10 out1 on by write", {6'd0, out1, out2}, 8'h02);
    wr_reg(OUT2, 8'h5A);
    chk("R10 out2 on by write", {6'd0, out1, out2}, 8'h03);
    rd_reg(CTRL, v); chk("R10 ctrl shows outputs", v, 8'h06);
    rd_reg(OUT1, v);
    chk("R10 out1 off by read", {6'd0, out1, out2}, 8'h01);
    rd_reg(OUT2, v);
    chk("R10 out2 off by read", {6'd0, out1, out2}, 8'h00);
    wr_reg(CTRL, 8'h02);
    chk("R10 ctrl bit1 drives out1", {6'd0, out1, out2}, 8'h02);
  endtask

  task automatic t_ctrl();
    wr_reg(CTRL, 8'h71);
    chk("R12 control outputs", {5'd0, wdt_en, tmr_slow, fan_tgl}, 8'h07);
    chk("R12 outs cleared by ctrl", {6'd0, out1, out2}, 8'h00);
    rd_reg(CTRL, v); chk("R12 ctrl readback", v, 8'h71);
  endtask

  task automatic t_rstreq();
    wr_reg(IEN, 8'h00);
    wr_reg(CTRL, 8'h20);
    @(negedge clk); pb_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 pushbutton reset", {7'd0, rst_req}, 8'h01);
    pb_n = 1'b1; repeat (2) @(negedge clk);
    chk("R9 pushbutton released", {7'd0, rst_req}, 8'h00);
    wr_reg(CTRL, 8'h00);
    pb_n = 1'b0; repeat (2) @(negedge clk);
    chk("R9 pushbutton gated off", {7'd0, rst_req}, 8'h00);
    pb_n = 1'b1; iso_in2 = 1'b1; repeat (2) @(negedge clk);
    chk("R9 iso input gated off", {7'd0, rst_req}, 8'h00);
    wr_reg(CTRL, 8'h08); @(negedge clk);
    chk("R9 iso input reset", {7'd0, rst_req}, 8'h01);
    iso_in2 = 1'b0; wdt_expired = 1'b1; repeat (2) @(negedge clk);
    chk("R9 watchdog reset", {7'd0, rst_req}, 8'h01);
    wdt_expired = 1'b0; repeat (2) @(negedge clk);
    chk("R9 all terms low", {7'd0, rst_req}, 8'h00);
  endtask

  initial begin
    rst = 1'b1; addr = '0; rd = 0; wr = 0; wdata = '0;
    wdt_expired = 0; wdt_warn = 0; temp_over = 0; ov5 = 0; uv5 = 0;
    flt12p = 0; flt12n = 0; fan_limit = 0; fan_ok = 1; iso_in1 = 0; iso_in2 = 0;
    pb_n = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_layout();
    t_enable_seq();
    t_disable();
    t_image();
    t_gating();
    t_collision();
    t_held();
    t_global();
    t_outputs();
    t_ctrl();
    t_rstreq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule